// File: doc/BRIEF.md
# Bus-Arbitrated Block Transfer Engine

This block moves a run of data words between a device-side stream and system memory on behalf of the processor. Software sets a starting word address, a word count and a direction through a small register window. It then writes a start bit. The engine asks the processor for the shared address and data buses and waits until the processor hands them over. It then drives every memory cycle of the transfer itself. When the last word has moved, it lets go of the buses and raises a completion flag.

The device side uses two valid/ready streams. The inbound stream supplies words that are written to memory. The outbound stream delivers words read from memory. Memory is a simple synchronous port: a write takes effect at the clock edge of its strobe, and read data is returned in the cycle after the read strobe. If the processor takes the grant back partway through, the engine pauses and resumes without losing a word.

Top module: `dma_bus_master`

## Requirements
- R1: After reset, bus_req, mem_en, mem_we, dev_out_valid and done_irq are low, and the control/status word (offset 2) reads 0.
- R2: Register window: offset 0 sets the start word address, offset 1 sets the word count, and offset 2 is control. In the control word, bit0 starts a transfer, bit1 selects the direction (0 = device to memory, 1 = memory to device) and bit2 clears the completion flag. Offset 2 reads back {done at bit2, direction at bit1, busy at bit0}. Offsets 0 and 1 read back the live address and the remaining count. While a transfer is busy, writes to offsets 0 and 1 and the start bit are ignored.
- R3: A start with a nonzero count raises bus_req in the next cycle. bus_req stays high until the transfer ends. No memory cycle is issued unless bus_gnt is high.
- R4: While bus_gnt is low, mem_en, mem_we, mem_addr and mem_wdata are all zero.
- R5: Device to memory: each inbound handshake (dev_in_valid and dev_in_ready) writes dev_in_data in that same cycle at the current address. The address then increments by one word and the count decrements by one.
- R6: Memory to device: each word is read at the current address, and the returned data is offered on dev_out_data. dev_out_valid stays high and the data stays stable until dev_out_ready is seen.
- R7: In the cycle after the handshake of the final word, bus_req is low and done_irq is high.
- R8: done_irq is sticky. It stays high until a control write with bit2 set clears it.
- R9: A start with a count of zero sets done_irq in the next cycle and never raises bus_req.
- R10: If bus_gnt drops partway through a transfer, the transfer pauses. Once the grant returns, it finishes with every word moved in order to the right address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| bus_req | output | 1 | Request for the shared buses |
| bus_gnt | input | 1 | Grant of the shared buses from the processor |
| mem_en | output | 1 | Memory cycle strobe |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after a read strobe |
| dev_in_valid | input | 1 | Inbound device word available |
| dev_in_data | input | DW | Inbound device word |
| dev_in_ready | output | 1 | Engine accepts the inbound word |
| dev_out_valid | output | 1 | Outbound word available to the device |
| dev_out_data | output | DW | Outbound word |
| dev_out_ready | input | 1 | Device accepts the outbound word |
| done_irq | output | 1 | Sticky completion flag |

## Verification
A wrong state in the sequencer shows at the ports within a cycle or two. A stuck or skipped request state shows as bus_req that never rises, or as a memory strobe with no grant. A bad address or count register shows as data landing at the wrong word, or as the release coming one word early or late, and the live address and count readbacks expose both. A bad completion path shows as done_irq rising while bus_req is still high, or as the flag clearing with no clear write, and both are caught in the cycle after the fault.

// File: rtl/dma_bus_master.sv
module dma_bus_master #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_out_ready,
  output logic          done_irq
);
  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_CNT  = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam int BIT_GO  = 0;
  localparam int BIT_DIR = 1;
  localparam int BIT_CLR = 2;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WR, S_RD, S_RWAIT, S_PUSH} st_t;

  st_t           st_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q;
  logic          done_q;
  logic [DW-1:0] buf_q;

  logic idle, ctrl_wr, go, last, wr_beat, rd_issue, push_beat, beat;

  assign idle      = (st_q == S_IDLE);
  assign ctrl_wr   = reg_wr && (reg_addr == OFS_CTRL);
  assign go        = ctrl_wr && reg_wdata[BIT_GO] && idle;
  assign last      = (cnt_q == CW'(1));
  assign wr_beat   = (st_q == S_WR) && bus_gnt && dev_in_valid;
  assign rd_issue  = (st_q == S_RD) && bus_gnt;
  assign push_beat = (st_q == S_PUSH) && dev_out_ready;
  assign beat      = wr_beat || push_beat;

  assign bus_req       = !idle;
  assign dev_in_ready  = (st_q == S_WR) && bus_gnt;
  assign mem_en        = wr_beat || rd_issue;
  assign mem_we        = wr_beat;
  assign mem_addr      = mem_en ? addr_q : '0;
  assign mem_wdata     = wr_beat ? dev_in_data : '0;
  assign dev_out_valid = (st_q == S_PUSH);
  assign dev_out_data  = buf_q;
  assign done_irq      = done_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_ADDR: reg_rdata[AW-1:0] = addr_q;
      OFS_CNT:  reg_rdata[CW-1:0] = cnt_q;
      OFS_CTRL: reg_rdata[2:0]    = {done_q, dir_q, !idle};
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (idle && reg_wr && reg_addr == OFS_ADDR) addr_q <= reg_wdata[AW-1:0];
      if (idle && reg_wr && reg_addr == OFS_CNT)  cnt_q  <= reg_wdata[CW-1:0];
      if (ctrl_wr && reg_wdata[BIT_CLR]) done_q <= 1'b0;
      if (beat) begin
        addr_q <= addr_q + AW'(1);
        cnt_q  <= cnt_q - CW'(1);
      end
      if (go && cnt_q == '0) done_q <= 1'b1;
      if (beat && last)      done_q <= 1'b1;

      case (st_q)
        S_IDLE: if (go) begin
          dir_q <= reg_wdata[BIT_DIR];
          if (cnt_q != '0) st_q <= S_REQ;
        end
        S_REQ:   if (bus_gnt) st_q <= dir_q ? S_RD : S_WR;
        S_WR:    if (wr_beat && last) st_q <= S_IDLE;
        S_RD:    if (rd_issue) st_q <= S_RWAIT;
        S_RWAIT: begin
          buf_q <= mem_rdata;
          st_q  <= S_PUSH;
        end
        S_PUSH:  if (push_beat) st_q <= last ? S_IDLE : S_RD;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_bus_master_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          dev_in_valid,
  input logic          dev_in_ready,
  input logic          dev_out_valid,
  input logic [DW-1:0] dev_out_data,
  input logic          dev_out_ready,
  input logic          done_irq
);
  assert_mem_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (bus_gnt && bus_req));

  assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |-> (!mem_en && !mem_we && mem_addr == '0 && mem_wdata == '0));

  assert_write_from_device_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (dev_in_valid && dev_in_ready));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));

  assert_release_sets_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> done_irq);

  assert_done_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> !bus_req);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !(reg_wr && reg_addr == 2'd2 && reg_wdata[2])) |=> done_irq);
endmodule

bind dma_bus_master dma_bus_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
  .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
  .dev_out_ready(dev_out_ready), .done_irq(done_irq)
);

// File: tb/dma_bus_master_tb.sv
module dma_bus_master_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          bus_req;
  logic          bus_gnt;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          dev_in_valid = 1'b0;
  logic [DW-1:0] dev_in_data = '0;
  logic          dev_in_ready;
  logic          dev_out_valid;
  logic [DW-1:0] dev_out_data;
  logic          dev_out_ready = 1'b0;
  logic          done_irq;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  int gnt_delay = 2;
  logic gnt_block = 1'b0;
  int gcnt;
  logic pl_en = 1'b0;
  logic [7:0] pl_addr = '0;
  logic [DW-1:0] pl_data = '0;
  logic [DW-1:0] mem_arr [0:255];
  logic [DW-1:0] rx [0:15];

  always #4 clk = ~clk;

  dma_bus_master #(.AW(AW), .DW(DW), .CW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_in_valid(dev_in_valid),
    .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_ready(dev_out_ready), .done_irq(done_irq)
  );

  always @(posedge clk) begin
    if (pl_en) mem_arr[pl_addr] <= pl_data;
    if (mem_en && mem_we) mem_arr[mem_addr[7:0]] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem_arr[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0;
      gcnt <= 0;
    end else begin
      if (bus_req && !gnt_block) begin
        if (gcnt >= gnt_delay) bus_gnt <= 1'b1;
        else gcnt <= gcnt + 1;
      end else begin
        bus_gnt <= 1'b0;
        gcnt <= 0;
      end
      if (mem_en && !bus_gnt) viol <= viol + 1;
      if (mem_en && !bus_req) viol <= viol + 1;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic preload(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic send_words(input int n, input logic [DW-1:0] base, input string tag);
    for (int i = 0; i < n; i++) begin
      dev_in_valid = 1'b1;
      dev_in_data = base + DW'(i);
      #1;
      while (!dev_in_ready) begin
        @(negedge clk);
        #1;
      end
      if (i == n - 1) chk({tag, " R3 bus_req held at last word"}, DW'(bus_req), 1);
      @(negedge clk);
    end
    dev_in_valid = 1'b0;
    chk({tag, " R7 bus_req low after last word"}, DW'(bus_req), 0);
    chk({tag, " R7 done high after last word"}, DW'(done_irq), 1);
  endtask

  task automatic recv_words(input int n, input string tag);
    int k = 0;
    int cyc = 0;
    while (k < n) begin
      @(negedge clk);
      dev_out_ready = (cyc % 3) != 1;
      cyc++;
      #1;
      if (dev_out_valid && dev_out_ready) begin
        rx[k] = dev_out_data;
        k++;
      end
    end
    @(negedge clk);
    dev_out_ready = 1'b0;
    chk({tag, " R7 bus_req low after last word"}, DW'(bus_req), 0);
    chk({tag, " R7 done high after last word"}, DW'(done_irq), 1);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 bus_req", DW'(bus_req), 0);
    chk("R1 mem_en", DW'(mem_en), 0);
    chk("R1 mem_we", DW'(mem_we), 0);
    chk("R1 dev_out_valid", DW'(dev_out_valid), 0);
    chk("R1 done_irq", DW'(done_irq), 0);
    rd(2'd2, v);
    chk("R1 status", v, 0);
  endtask

  task automatic t_dev_to_mem();
    logic [DW-1:0] v;
    gnt_delay = 3;
    wr(2'd0, 32'h10);
    wr(2'd1, 32'd4);
    wr(2'd2, 32'h1);
    chk("R3 bus_req after start", DW'(bus_req), 1);
    rd(2'd2, v);
    chk("R2 status busy dir0", v, 32'h1);
    send_words(4, 32'hC0DE_0000, "dev2mem");
    for (int i = 0; i < 4; i++)
      chk("R5 memory word", mem_arr[8'h10 + i], 32'hC0DE_0000 + DW'(i));
    rd(2'd0, v);
    chk("R2 R5 final address", v, 32'h14);
    rd(2'd1, v);
    chk("R2 R5 final count", v, 0);
    chk("R3 no memory cycle without grant", DW'(viol), 0);
  endtask

  task automatic t_sticky();
    logic [DW-1:0] v;
    repeat (10) @(negedge clk);
    chk("R8 done held", DW'(done_irq), 1);
    wr(2'd2, 32'h0);
    chk("R8 done held after plain write", DW'(done_irq), 1);
    rd(2'd2, v);
    chk("R2 R8 status done bit", v, 32'h4);
    wr(2'd2, 32'h4);
    chk("R8 done cleared", DW'(done_irq), 0);
  endtask

  task automatic t_mem_to_dev();
    logic [DW-1:0] v;
    for (int i = 0; i < 5; i++) preload(8'h20 + 8'(i), 32'hA000 + DW'(i * 7));
    gnt_delay = 2;
    wr(2'd0, 32'h20);
    wr(2'd1, 32'd5);
    wr(2'd2, 32'h3);
    rd(2'd2, v);
    chk("R2 status busy dir1", v, 32'h3);
    recv_words(5, "mem2dev");
    for (int i = 0; i < 5; i++) chk("R6 outbound word", rx[i], 32'hA000 + DW'(i * 7));
    rd(2'd0, v);
    chk("R6 final address", v, 32'h25);
    wr(2'd2, 32'h4);
  endtask

  task automatic t_zero_len();
    int bad = 0;
    wr(2'd1, 32'd0);
    wr(2'd2, 32'h1);
    chk("R9 done next cycle", DW'(done_irq), 1);
    for (int i = 0; i < 8; i++) begin
      if (bus_req) bad++;
      @(negedge clk);
    end
    chk("R9 bus_req never raised", DW'(bad), 0);
    wr(2'd2, 32'h4);
  endtask

  task automatic t_busy_ignore();
    logic [DW-1:0] v;
    preload(8'h80, 32'hDEAD_BEEF);
    gnt_block = 1'b1;
    wr(2'd0, 32'h40);
    wr(2'd1, 32'd2);
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h80);
    wr(2'd1, 32'd9);
    wr(2'd2, 32'h3);
    rd(2'd0, v);
    chk("R2 address write ignored while busy", v, 32'h40);
    rd(2'd1, v);
    chk("R2 count write ignored while busy", v, 32'd2);
    rd(2'd2, v);
    chk("R2 start ignored while busy", v, 32'h1);
    chk("R4 mem_en low before grant", DW'(mem_en), 0);
    gnt_block = 1'b0;
    gnt_delay = 0;
    send_words(2, 32'h5500, "busy");
    chk("R2 word 0 at first address", mem_arr[8'h40], 32'h5500);
    chk("R2 word 1 at first address", mem_arr[8'h41], 32'h5501);
    chk("R2 ignored address untouched", mem_arr[8'h80], 32'hDEAD_BEEF);
    wr(2'd2, 32'h4);
  endtask

  task automatic t_withdraw();
    int low_seen = 0;
    int bad = 0;
    gnt_delay = 1;
    wr(2'd0, 32'h60);
    wr(2'd1, 32'd6);
    wr(2'd2, 32'h1);
    fork
      send_words(6, 32'h7700, "withdraw");
      begin
        repeat (3) @(negedge clk);
        gnt_block = 1'b1;
        repeat (6) begin
          @(negedge clk);
          #2;
          if (!bus_gnt) begin
            low_seen++;
            if (mem_en || mem_we || mem_addr != '0 || mem_wdata != '0) bad++;
          end
        end
        gnt_block = 1'b0;
      end
    join
    chk("R10 grant was withdrawn", DW'(low_seen > 0), 1);
    chk("R4 outputs zero while grant low", DW'(bad), 0);
    for (int i = 0; i < 6; i++)
      chk("R10 word after pause", mem_arr[8'h60 + i], 32'h7700 + DW'(i));
    chk("R3 no memory cycle without grant", DW'(viol), 0);
    wr(2'd2, 32'h4);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dev_to_mem();
        t_sticky();
        t_mem_to_dev();
        t_zero_len();
        t_busy_ignore();
        t_withdraw();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule